// File: doc/BRIEF.md
# Effective Address and Cycle Cost Unit

This block forms the 16-bit offset of a memory operand from up to one base register, up to one index register and a displacement, and, at the same time, tells how many clock cycles that address computation costs. It receives the current contents of the four addressing registers (base-extended `regBx`, base-pointer `regBp`, source index `regSi`, destination index `regDi`), a 5-bit mode code that selects the components, a 16-bit displacement, a flag marking a word-sized operand and a segment-override request with the override segment.

One clock after a request (`inValid` high at a rising edge), the block presents the offset, the segment that applies, the cycle cost and an error flag, qualified by a one-cycle `outValid` pulse. The cycle cost depends on which registers are paired. A word access at an odd offset and a segment override each add a penalty. Mode codes that select two bases or two indexes are reported as errors.

Top module: `ea_cost_unit`

## Requirements
- R1: Results appear exactly one clock after a request: `outValid` is high in the cycle after `inValid` was sampled high and low otherwise, and it is low after reset.
- R2: The mode code is {dispEn, baseField[1:0], indexField[1:0]} (bit 4 down to bit 0). baseField 0 means no base, 1 means `regBx`, 2 means `regBp` and 3 is illegal. indexField 0 means no index, 1 means `regSi`, 2 means `regDi` and 3 is illegal. For a legal code, `eaOut` is the sum of the selected registers plus `disp` (when dispEn is set, or when no register is selected), taken modulo 2^16.
- R3: With no register selected, the operand is a bare displacement and costs 6 cycles, whatever dispEn says. One register alone costs 5 cycles, and one register plus the displacement costs 9.
- R4: A base and an index without the displacement cost 7 cycles for the pairs BP+DI and BX+SI, and 8 cycles for the pairs BP+SI and BX+DI.
- R5: A base, an index and the displacement cost 11 cycles for BP+DI and BX+SI, and 12 cycles for BP+SI and BX+DI.
- R6: When `wordOp` is set and `eaOut` is odd, 4 cycles are added. A byte operand, or an even offset, adds nothing.
- R7: When `ovrEn` is set, 2 cycles are added and `segOut` equals `ovrSeg`.
- R8: Without an override, `segOut` is 2 (stack) when the base is BP and 3 (data) otherwise. The segment codes are 0 extra, 1 code, 2 stack, 3 data.
- R9: An illegal mode code sets `errOut` and returns `cyclesOut` = 0, `eaOut` = 0 and `segOut` = 3, regardless of the other inputs. A legal code clears `errOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe |
| modeCode | input | 5 | Component selection {dispEn, baseField, indexField} |
| regBx | input | 16 | Base register BX value |
| regBp | input | 16 | Base pointer BP value |
| regSi | input | 16 | Source index SI value |
| regDi | input | 16 | Destination index DI value |
| disp | input | 16 | Displacement |
| wordOp | input | 1 | Operand is a 16-bit word |
| ovrEn | input | 1 | Segment override requested |
| ovrSeg | input | 2 | Override segment code |
| outValid | output | 1 | Result strobe, one cycle after request |
| eaOut | output | 16 | Effective address |
| segOut | output | 2 | Segment that applies |
| cyclesOut | output | 5 | Address calculation cost in cycles |
| errOut | output | 1 | Illegal mode code |

## Verification
The bench aims at the pairings that share a component count but differ in cost: BX+SI against BX+DI, and BP+DI against BP+SI, each with and without the displacement. A design that swapped the fast and slow pairs would report 7 where 8 is due. It also forces odd and even sums whose sum wraps past 0xFFFF, with word and byte operands. A wrong parity source, or a penalty taken from the displacement alone, shows up as a cost wrong by 4. Register-less codes with dispEn clear, BP-based modes with and without an override, and the illegal codes combined with an override and an odd word operand are driven as directed cases. These catch a design that charges 5 for a bare displacement, keeps the data segment for BP, or leaks a penalty into an error result.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int SEG_W = 2;
  localparam int BASE_COST_W = 4;

  typedef enum logic [SEG_W-1:0] {
    SEG_EXTRA = 2'd0,
    SEG_CODE  = 2'd1,
    SEG_STACK = 2'd2,
    SEG_DATA  = 2'd3
  } seg_e;

  localparam logic [BASE_COST_W-1:0] COST_DISP_ONLY     = 4'd6;
  localparam logic [BASE_COST_W-1:0] COST_ONE_REG       = 4'd5;
  localparam logic [BASE_COST_W-1:0] COST_ONE_REG_DISP  = 4'd9;
  localparam logic [BASE_COST_W-1:0] COST_PAIR_FAST     = 4'd7;
  localparam logic [BASE_COST_W-1:0] COST_PAIR_SLOW     = 4'd8;
  localparam logic [BASE_COST_W-1:0] COST_PAIR_FAST_D   = 4'd11;
  localparam logic [BASE_COST_W-1:0] COST_PAIR_SLOW_D   = 4'd12;
  localparam int PEN_ODD_WORD = 4;
  localparam int PEN_OVERRIDE = 2;

  typedef struct packed {
    logic useBx;
    logic useBp;
    logic useSi;
    logic useDi;
    logic useDisp;
    logic illegal;
    logic [BASE_COST_W-1:0] baseCost;
  } eaStrobes_t;
endpackage

// File: rtl/ea_ctrl.sv
module ea_ctrl
  import ea_pkg::*;
#(
  parameter int MODE_W = 5
) (
  input  logic [MODE_W-1:0] modeCode,
  output eaStrobes_t        strobes
);
  logic       dispEn;
  logic [1:0] baseField;
  logic [1:0] idxField;
  logic       hasBase;
  logic       hasIdx;
  logic       fastPair;

  assign dispEn    = modeCode[4];
  assign baseField = modeCode[3:2];
  assign idxField  = modeCode[1:0];
  assign hasBase   = (baseField != 2'd0);
  assign hasIdx    = (idxField != 2'd0);
  assign fastPair  = (baseField == 2'd1 && idxField == 2'd1) ||
                     (baseField == 2'd2 && idxField == 2'd2);

  always_comb begin
    strobes = '0;
    if (baseField == 2'd3 || idxField == 2'd3) begin
      strobes.illegal = 1'b1;
    end else begin
      strobes.useBx = (baseField == 2'd1);
      strobes.useBp = (baseField == 2'd2);
      strobes.useSi = (idxField == 2'd1);
      strobes.useDi = (idxField == 2'd2);
      if (!hasBase && !hasIdx) begin
        strobes.useDisp  = 1'b1;
        strobes.baseCost = COST_DISP_ONLY;
      end else if (hasBase && hasIdx) begin
        strobes.useDisp = dispEn;
        if (fastPair) strobes.baseCost = dispEn ? COST_PAIR_FAST_D : COST_PAIR_FAST;
        else          strobes.baseCost = dispEn ? COST_PAIR_SLOW_D : COST_PAIR_SLOW;
      end else begin
        strobes.useDisp  = dispEn;
        strobes.baseCost = dispEn ? COST_ONE_REG_DISP : COST_ONE_REG;
      end
    end
  end
endmodule

// File: rtl/ea_datapath.sv
module ea_datapath
  import ea_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CYC_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  eaStrobes_t        strobes,
  input  logic [ADDR_W-1:0] regBx,
  input  logic [ADDR_W-1:0] regBp,
  input  logic [ADDR_W-1:0] regSi,
  input  logic [ADDR_W-1:0] regDi,
  input  logic [ADDR_W-1:0] disp,
  input  logic              wordOp,
  input  logic              ovrEn,
  input  logic [SEG_W-1:0]  ovrSeg,
  output logic              outValid,
  output logic [ADDR_W-1:0] eaOut,
  output logic [SEG_W-1:0]  segOut,
  output logic [CYC_W-1:0]  cyclesOut,
  output logic              errOut
);
  localparam logic [CYC_W-1:0] ODD_PEN = CYC_W'(PEN_ODD_WORD);
  localparam logic [CYC_W-1:0] OVR_PEN = CYC_W'(PEN_OVERRIDE);

  logic [ADDR_W-1:0] baseTerm;
  logic [ADDR_W-1:0] idxTerm;
  logic [ADDR_W-1:0] dispTerm;
  logic [ADDR_W-1:0] eaNext;
  logic [CYC_W-1:0]  costNext;
  logic [SEG_W-1:0]  segNext;

  always_comb begin
    baseTerm = strobes.useBx ? regBx : (strobes.useBp ? regBp : '0);
    idxTerm  = strobes.useSi ? regSi : (strobes.useDi ? regDi : '0);
    dispTerm = strobes.useDisp ? disp : '0;
    eaNext   = strobes.illegal ? '0 : baseTerm + idxTerm + dispTerm;
  end

  always_comb begin
    costNext = '0;
    if (!strobes.illegal) begin
      costNext = CYC_W'(strobes.baseCost);
      if (wordOp && eaNext[0]) costNext = costNext + ODD_PEN;
      if (ovrEn)               costNext = costNext + OVR_PEN;
    end
  end

  always_comb begin
    if (strobes.illegal)    segNext = SEG_DATA;
    else if (ovrEn)         segNext = ovrSeg;
    else if (strobes.useBp) segNext = SEG_STACK;
    else                    segNext = SEG_DATA;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      eaOut     <= '0;
      segOut    <= SEG_DATA;
      cyclesOut <= '0;
      errOut    <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        eaOut     <= eaNext;
        segOut    <= segNext;
        cyclesOut <= costNext;
        errOut    <= strobes.illegal;
      end
    end
  end
endmodule

// File: rtl/ea_cost_unit.sv
module ea_cost_unit
  import ea_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CYC_W  = 5,
  parameter int MODE_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [MODE_W-1:0] modeCode,
  input  logic [ADDR_W-1:0] regBx,
  input  logic [ADDR_W-1:0] regBp,
  input  logic [ADDR_W-1:0] regSi,
  input  logic [ADDR_W-1:0] regDi,
  input  logic [ADDR_W-1:0] disp,
  input  logic              wordOp,
  input  logic              ovrEn,
  input  logic [1:0]        ovrSeg,
  output logic              outValid,
  output logic [ADDR_W-1:0] eaOut,
  output logic [1:0]        segOut,
  output logic [CYC_W-1:0]  cyclesOut,
  output logic              errOut
);
  eaStrobes_t strobes;

  ea_ctrl #(.MODE_W(MODE_W)) u_ctrl (
    .modeCode(modeCode),
    .strobes (strobes)
  );

  ea_datapath #(.ADDR_W(ADDR_W), .CYC_W(CYC_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobes  (strobes),
    .regBx    (regBx),
    .regBp    (regBp),
    .regSi    (regSi),
    .regDi    (regDi),
    .disp     (disp),
    .wordOp   (wordOp),
    .ovrEn    (ovrEn),
    .ovrSeg   (ovrSeg),
    .outValid (outValid),
    .eaOut    (eaOut),
    .segOut   (segOut),
    .cyclesOut(cyclesOut),
    .errOut   (errOut)
  );
endmodule

// File: rtl/ea_cost_checker.sv
module ea_cost_checker #(
  parameter int CYC_W  = 5,
  parameter int MODE_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [MODE_W-1:0] modeCode,
  input logic              ovrEn,
  input logic [1:0]        ovrSeg,
  input logic              outValid,
  input logic [1:0]        segOut,
  input logic [CYC_W-1:0]  cyclesOut,
  input logic              errOut
);
  logic legalCode;
  assign legalCode = (modeCode[3:2] != 2'd3) && (modeCode[1:0] != 2'd3);

  p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  p_valid_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  p_err_no_cost_r9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && errOut) |-> (cyclesOut == '0));

  p_err_flag_r9: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !legalCode) |=> errOut);

  p_cost_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !errOut) |-> (cyclesOut >= CYC_W'(5) && cyclesOut <= CYC_W'(18)));

  p_override_seg_r7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && ovrEn && legalCode) |=> (segOut == $past(ovrSeg)));

  p_bp_stack_r8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !ovrEn && legalCode && modeCode[3:2] == 2'd2) |=> (segOut == 2'd2));
endmodule

bind ea_cost_unit ea_cost_checker #(.CYC_W(CYC_W), .MODE_W(MODE_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .modeCode (modeCode),
  .ovrEn    (ovrEn),
  .ovrSeg   (ovrSeg),
  .outValid (outValid),
  .segOut   (segOut),
  .cyclesOut(cyclesOut),
  .errOut   (errOut)
);

// File: tb/tb_ea_cost_unit.sv
`timescale 1ns/1ps
module tb_ea_cost_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [4:0]  modeCode = '0;
  logic [15:0] regBx = '0, regBp = '0, regSi = '0, regDi = '0, disp = '0;
  logic        wordOp = 1'b0, ovrEn = 1'b0;
  logic [1:0]  ovrSeg = '0;
  logic        outValid;
  logic [15:0] eaOut;
  logic [1:0]  segOut;
  logic [4:0]  cyclesOut;
  logic        errOut;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  ea_cost_unit dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .modeCode(modeCode),
    .regBx(regBx), .regBp(regBp), .regSi(regSi), .regDi(regDi), .disp(disp),
    .wordOp(wordOp), .ovrEn(ovrEn), .ovrSeg(ovrSeg),
    .outValid(outValid), .eaOut(eaOut), .segOut(segOut),
    .cyclesOut(cyclesOut), .errOut(errOut)
  );

  function automatic bit isIllegal(input logic [4:0] m);
    return (m[3:2] == 2'd3) || (m[1:0] == 2'd3);
  endfunction

  function automatic logic [15:0] expEa(input logic [4:0] m);
    logic [15:0] s;
    if (isIllegal(m)) return 16'd0;
    s = 16'd0;
    if (m[3:2] == 2'd1) s = s + regBx;
    if (m[3:2] == 2'd2) s = s + regBp;
    if (m[1:0] == 2'd1) s = s + regSi;
    if (m[1:0] == 2'd2) s = s + regDi;
    if (m[4] || m[3:0] == 4'd0) s = s + disp;
    return s;
  endfunction

  function automatic logic [4:0] expCycles(input logic [4:0] m);
    int c;
    int nregs;
    bit fast;
    if (isIllegal(m)) return 5'd0;
    nregs = int'(m[3:2] != 0) + int'(m[1:0] != 0);
    fast = (m[3:2] == m[1:0]);
    if (nregs == 0) c = 6;
    else if (nregs == 1) c = m[4] ? 9 : 5;
    else c = fast ? (m[4] ? 11 : 7) : (m[4] ? 12 : 8);
    if (wordOp && expEa(m)[0]) c += 4;
    if (ovrEn) c += 2;
    return 5'(c);
  endfunction

  function automatic logic [1:0] expSeg(input logic [4:0] m);
    if (isIllegal(m)) return 2'd3;
    if (ovrEn) return ovrSeg;
    if (m[3:2] == 2'd2) return 2'd2;
    return 2'd3;
  endfunction

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Drive one request at a negedge, check the result one negedge later
  task automatic runVec(input string tag, input logic [4:0] m);
    logic [15:0] eEa;
    logic [4:0]  eCyc;
    logic [1:0]  eSeg;
    modeCode = m;
    inValid = 1'b1;
    eEa = expEa(m);
    eCyc = expCycles(m);
    eSeg = expSeg(m);
    @(negedge clk);
    inValid = 1'b0;
    cmp(tag, "outValid (R1)", int'(outValid), 1);
    cmp(tag, "eaOut (R2)", int'(eaOut), int'(eEa));
    cmp(tag, "cyclesOut", int'(cyclesOut), int'(eCyc));
    cmp(tag, "segOut", int'(segOut), int'(eSeg));
    cmp(tag, "errOut (R9)", int'(errOut), int'(isIllegal(m)));
    @(negedge clk);
    cmp(tag, "outValid idle R1", int'(outValid), 0);
  endtask

  task automatic setRegs(input logic [15:0] bx, bp, si, di, d);
    regBx = bx; regBp = bp; regSi = si; regDi = di; disp = d;
  endtask

  initial begin
    #400000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    cmp("R1", "reset outValid", int'(outValid), 0);
    cmp("R9", "reset errOut", int'(errOut), 0);
    rstN = 1'b1;
    @(negedge clk);
    cmp("R1", "no request outValid", int'(outValid), 0);

    // Even-valued registers: base costs only
    setRegs(16'h1000, 16'h2000, 16'h0300, 16'h0040, 16'h0006);
    runVec("R3 disp only", 5'b0_00_00);
    runVec("R3 disp only dispEn clear", 5'b0_00_00);
    runVec("R3 disp only dispEn set", 5'b1_00_00);
    runVec("R3 BX alone", 5'b0_01_00);
    runVec("R3 SI alone", 5'b0_00_01);
    runVec("R3 BP plus disp", 5'b1_10_00);
    runVec("R3 DI plus disp", 5'b1_00_10);
    runVec("R4 BX+SI", 5'b0_01_01);
    runVec("R4 BX+DI", 5'b0_01_10);
    runVec("R4 BP+DI", 5'b0_10_10);
    runVec("R4 BP+SI", 5'b0_10_01);
    runVec("R5 BX+SI+d", 5'b1_01_01);
    runVec("R5 BX+DI+d", 5'b1_01_10);
    runVec("R5 BP+DI+d", 5'b1_10_10);
    runVec("R5 BP+SI+d", 5'b1_10_01);

    // Wrap-around of the sum (R2)
    setRegs(16'hFFF0, 16'h8000, 16'h0020, 16'h8001, 16'hFFFF);
    runVec("R2 wrap BX+SI+d", 5'b1_01_01);
    runVec("R2 wrap BP+DI", 5'b0_10_10);

    // Odd-word penalty (R6)
    wordOp = 1'b1;
    runVec("R6 odd word BP+DI", 5'b0_10_10);
    runVec("R6 even word BX+SI", 5'b0_01_01);
    wordOp = 1'b0;
    runVec("R6 odd byte BP+DI", 5'b0_10_10);

    // Override (R7) and default segment (R8)
    ovrEn = 1'b1; ovrSeg = 2'd1;
    runVec("R7 override on BP", 5'b0_10_00);
    ovrSeg = 2'd0;
    runVec("R7 override on BX", 5'b1_01_10);
    ovrEn = 1'b0;
    runVec("R8 BP default stack", 5'b0_10_01);
    runVec("R8 BX default data", 5'b0_01_00);

    // Illegal codes (R9) with penalties that must not leak
    wordOp = 1'b1; ovrEn = 1'b1; ovrSeg = 2'd2;
    runVec("R9 two bases", 5'b1_11_00);
    runVec("R9 two indexes", 5'b0_10_11);
    runVec("R9 both illegal", 5'b1_11_11);
    wordOp = 1'b0; ovrEn = 1'b0;

    // Back-to-back requests (R1)
    setRegs(16'h0010, 16'h0020, 16'h0001, 16'h0002, 16'h0100);
    modeCode = 5'b0_01_01; inValid = 1'b1;
    @(negedge clk);
    cmp("R1", "b2b first valid", int'(outValid), 1);
    cmp("R1", "b2b first ea", int'(eaOut), 16'h0011);
    modeCode = 5'b0_10_10;
    @(negedge clk);
    inValid = 1'b0;
    cmp("R1", "b2b second valid", int'(outValid), 1);
    cmp("R1", "b2b second ea", int'(eaOut), 16'h0022);
    @(negedge clk);
    cmp("R1", "b2b idle", int'(outValid), 0);

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      setRegs(16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom));
      wordOp = 1'($urandom);
      ovrEn  = (($urandom % 4) == 0);
      ovrSeg = 2'($urandom);
      runVec("RND", 5'($urandom));
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule